// File: doc/BRIEF.md
# Prefetch-Filtering Assist Buffer Controller

This block keeps the tags and placement for a direct-mapped main cache that works beside a small fully associative assist buffer. Every block that enters the cache, whether a returned demand fill or a speculative prefetch, first lands in the assist buffer. A block moves into the main cache only if it is referenced a second time while it still sits in the assist buffer. Blocks that are touched once, such as streamed data, age out of the assist buffer in arrival order and never displace anything in the main cache.

A demand lookup probes both structures in the same cycle. It reports a main hit, an assist hit, or a fill request that carries the missed block address. A returned fill is presented on a separate port and written into the assist buffer. A prefetch engine offers candidate blocks on a third port. Any insert whose block already exists in either structure is dropped. Addresses are block addresses. The low bits select the main-cache set and the remaining bits form the tag. No data is stored here.

Top module: `ab_prefetch_filter`

## Requirements
- R1: A lookup whose block is held in the main cache raises `main_hit` in the same cycle. It does not raise `assist_hit` or `fill_req`, and it changes no state.
- R2: A lookup that misses both structures raises `fill_req` in the same cycle, with `fill_req_addr` equal to `lk_addr`. The lookup itself changes no state.
- R3: A block presented on the fill port is written into the assist buffer and not into the main cache. A later lookup of that block reports `assist_hit`.
- R4: A prefetched block is written into the assist buffer and not into the main cache. A later lookup of that block reports `assist_hit` and not `main_hit`.
- R5: A lookup that hits the assist buffer promotes the block into the main-cache set selected by its low address bits. From the next cycle on, a lookup of that block reports `main_hit`.
- R6: When a promotion displaces a valid main-cache block, the displaced block takes the assist-buffer slot that the promoted block left. A later lookup of the displaced block reports `assist_hit`.
- R7: When a promotion fills an empty main-cache set, nothing is moved back. The promoted block is held only in the main cache from then on.
- R8: Inserts use a write pointer that wraps around the `AB_DEPTH` slots. An insert into an occupied slot discards the oldest entry, so after `AB_DEPTH` further inserts an earlier block misses. Assist-buffer traffic never changes the main cache except through promotion.
- R9: An insert whose block is already present in the main cache or in the assist buffer is ignored. It neither takes a slot nor advances the write pointer.
- R10: When a fill and a prefetch are offered in the same cycle, only the fill is inserted. The prefetch is dropped.
- R11: A promotion and an insert in the same cycle are both applied, and the promotion is applied first. If the write pointer points at the slot that the swap refilled, the inserted block overwrites the displaced block.
- R12: Reset empties both structures, and every output stays low while `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Demand lookup present |
| lk_addr | input | ADDR_W | Block address of the demand lookup |
| pf_valid | input | 1 | Prefetch insert offered |
| pf_addr | input | ADDR_W | Block address of the prefetch |
| fill_valid | input | 1 | Returned fill block present |
| fill_addr | input | ADDR_W | Block address of the returned fill |
| main_hit | output | 1 | Lookup hit in the main cache |
| assist_hit | output | 1 | Lookup hit in the assist buffer (a promotion follows) |
| fill_req | output | 1 | Lookup missed both structures |
| fill_req_addr | output | ADDR_W | Block address to fetch, valid with `fill_req` |

## Verification
The hardest situation to reach from the ports is a promotion that coincides with an insert whose write pointer points at the very slot the swap refills. To reach it, the stimulus first offers exactly enough fresh prefetches to wrap the pointer back onto the slot holding a block whose main set is occupied. It then looks up that block while offering a new prefetch in the same cycle. Duplicate filtering is exposed through eviction order: ignored duplicates must not push a still-wanted block out. The bench then looks that block up after one more real insert.

// File: rtl/ab_pkg.sv
// Package: shared selection type for the assist-buffer controller.
// Assumes: nothing beyond the standard types.
package ab_pkg;

    // Source of the single insert allowed per cycle.
    typedef enum logic [1:0] {
        INS_NONE = 2'd0,
        INS_FILL = 2'd1,
        INS_PREF = 2'd2
    } ins_src_e;

endpackage

// File: rtl/ab_main_dir.sv
// Module: tag directory of the direct-mapped main cache.
// Two combinational read ports (one for lookups, one for the insert
// presence check) and one write port used only by promotion.
// Assumes: the caller keeps every block in at most one structure.
module ab_main_dir #(
    parameter int SETS  = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [SETS-1:0]  set_vld;
    logic [TAG_W-1:0] set_tag [SETS];

    // Read ports: plain indexed reads.
    always_comb begin
        ra_valid = set_vld[ra_idx];
        ra_tag   = set_tag[ra_idx];
        rb_valid = set_vld[rb_idx];
        rb_tag   = set_tag[rb_idx];
    end

    // Storage: cleared on reset, written by promotion only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_vld <= '0;
            for (int s = 0; s < SETS; s++) set_tag[s] <= '0;
        end else if (wr_en) begin
            set_vld[wr_idx] <= 1'b1;
            set_tag[wr_idx] <= wr_tag;
        end
    end

    // R5: a promotion is visible in its set on the next cycle.
    a_r5_promote_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (set_vld[$past(wr_idx)] && set_tag[$past(wr_idx)] == $past(wr_tag)));

    // R8: without a promotion the main cache keeps its contents.
    a_r8_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(set_vld));

endmodule

// File: rtl/ab_assist_buf.sv
// Module: fully associative assist buffer with a FIFO write pointer.
// One lookup comparator bank and one presence-check bank. A swap port
// rewrites a single slot for promotion. An insert port writes at the
// pointer and advances it. The insert is applied after the swap, so on
// a shared slot the insert wins.
// Assumes: the caller only raises ins_en for addresses that are absent.
module ab_assist_buf #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 12,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_present,
    input  logic              sw_en,
    input  logic [SLOT_W-1:0] sw_slot,
    input  logic              sw_valid,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr
);

    logic [DEPTH-1:0]  ent_vld;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [SLOT_W-1:0] wptr;
    logic [SLOT_W-1:0] wptr_nxt;
    logic [DEPTH-1:0]  lk_match;
    logic [DEPTH-1:0]  chk_match;

    // Comparator banks, one pair per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_match[g]  = ent_vld[g] && (ent_addr[g] == lk_addr);
        assign chk_match[g] = ent_vld[g] && (ent_addr[g] == chk_addr);
    end

    // Encode the matching lookup slot (entries are unique).
    always_comb begin
        lk_slot = '0;
        for (int i = 0; i < DEPTH; i++)
            if (lk_match[i]) lk_slot = SLOT_W'(i);
    end

    assign lk_hit      = |lk_match;
    assign chk_present = |chk_match;

    // Pointer successor with a wrap that also suits depths that are not powers of two.
    always_comb begin
        if (wptr == SLOT_W'(DEPTH - 1)) wptr_nxt = '0;
        else                            wptr_nxt = wptr + 1'b1;
    end

    // Slot storage: swap first, insert second (later write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            wptr    <= '0;
            for (int i = 0; i < DEPTH; i++) ent_addr[i] <= '0;
        end else begin
            if (sw_en) begin
                ent_vld[sw_slot]  <= sw_valid;
                ent_addr[sw_slot] <= sw_addr;
            end
            if (ins_en) begin
                ent_vld[wptr]  <= 1'b1;
                ent_addr[wptr] <= ins_addr;
                wptr           <= wptr_nxt;
            end
        end
    end

    // R9: no block is ever held twice, so at most one slot matches.
    a_r9_unique_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    a_r9_unique_check: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_match));

    // R3: an insert occupies the slot the pointer named.
    a_r3_insert_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (ent_vld[$past(wptr)] && ent_addr[$past(wptr)] == $past(ins_addr)));

    // R8: the pointer stays inside the buffer.
    a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wptr) < DEPTH);

    // R7: a swap carrying nothing back frees its slot unless an insert reuses it.
    a_r7_swap_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !sw_valid && !(ins_en && wptr == sw_slot)) |=> !ent_vld[$past(sw_slot)]);

endmodule

// File: rtl/ab_prefetch_filter.sv
// Module: top-level lookup and placement controller. It probes the main
// directory and the assist buffer in parallel, drives promotion swaps,
// chooses the one insert per cycle (fill before prefetch) and drops
// inserts whose block is already held.
// Assumes: addresses are block addresses; the low IDX_W bits select the set.
module ab_prefetch_filter #(
    parameter int ADDR_W    = 12,
    parameter int MAIN_SETS = 16,
    parameter int AB_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              main_hit,
    output logic              assist_hit,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_req_addr
);
    import ab_pkg::*;

    localparam int IDX_W  = $clog2(MAIN_SETS);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int SLOT_W = $clog2(AB_DEPTH);

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              dir_a_vld;
    logic [TAG_W-1:0]  dir_a_tag;
    logic              dir_b_vld;
    logic [TAG_W-1:0]  dir_b_tag;
    logic              dir_hit_raw;
    logic              ab_hit_raw;
    logic [SLOT_W-1:0] ab_slot;
    logic              ab_present;
    logic              promote;
    ins_src_e          ins_src;
    logic [ADDR_W-1:0] ins_addr;
    logic              ins_present;
    logic              ins_en;

    assign lk_idx = lk_addr[IDX_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:IDX_W];

    // Pick the single insert candidate: fill outranks prefetch.
    always_comb begin
        if (fill_valid)    ins_src = INS_FILL;
        else if (pf_valid) ins_src = INS_PREF;
        else               ins_src = INS_NONE;
        case (ins_src)
            INS_FILL: ins_addr = fill_addr;
            INS_PREF: ins_addr = pf_addr;
            default:  ins_addr = '0;
        endcase
    end

    ab_main_dir #(
        .SETS  (MAIN_SETS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (lk_idx),
        .ra_valid (dir_a_vld),
        .ra_tag   (dir_a_tag),
        .rb_idx   (ins_addr[IDX_W-1:0]),
        .rb_valid (dir_b_vld),
        .rb_tag   (dir_b_tag),
        .wr_en    (promote),
        .wr_idx   (lk_idx),
        .wr_tag   (lk_tag)
    );

    ab_assist_buf #(
        .DEPTH  (AB_DEPTH),
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W)
    ) u_ab (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_addr     (lk_addr),
        .lk_hit      (ab_hit_raw),
        .lk_slot     (ab_slot),
        .chk_addr    (ins_addr),
        .chk_present (ab_present),
        .sw_en       (promote),
        .sw_slot     (ab_slot),
        .sw_valid    (dir_a_vld),
        .sw_addr     ({dir_a_tag, lk_idx}),
        .ins_en      (ins_en),
        .ins_addr    (ins_addr)
    );

    // Lookup outcome from the two parallel probes.
    always_comb begin
        dir_hit_raw   = dir_a_vld && (dir_a_tag == lk_tag);
        main_hit      = lk_valid && dir_hit_raw;
        assist_hit    = lk_valid && !dir_hit_raw && ab_hit_raw;
        fill_req      = lk_valid && !dir_hit_raw && !ab_hit_raw;
        fill_req_addr = fill_req ? lk_addr : '0;
        promote       = assist_hit;
    end

    // Insert gating: drop a candidate that either structure already holds.
    always_comb begin
        ins_present = ab_present ||
                      (dir_b_vld && dir_b_tag == ins_addr[ADDR_W-1:IDX_W]);
        ins_en      = (ins_src != INS_NONE) && !ins_present;
    end

    // R6: the two structures never hold the same block.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_hit_raw && ab_hit_raw));

    // R12: with no lookup, no lookup outcome is reported.
    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!main_hit && !assist_hit && !fill_req));

endmodule

// File: tb/ab_prefetch_filter_tb_top.sv
module ab_prefetch_filter_tb_top;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          pf_valid = 1'b0;
    logic [AW-1:0] pf_addr = '0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          main_hit;
    logic          assist_hit;
    logic          fill_req;
    logic [AW-1:0] fill_req_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ab_prefetch_filter #(.ADDR_W(AW), .MAIN_SETS(16), .AB_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .pf_valid(pf_valid), .pf_addr(pf_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .main_hit(main_hit), .assist_hit(assist_hit),
        .fill_req(fill_req), .fill_req_addr(fill_req_addr)
    );

    typedef struct packed {
        logic          lv;
        logic [AW-1:0] la;
        logic          pv;
        logic [AW-1:0] pa;
        logic          fv;
        logic [AW-1:0] fa;
        logic          em;
        logic          ea;
        logic          ef;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [NV] = '{
        '{1'b1,12'h101, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b0,1'b1, 4'd2 },  // R2 cold miss
        '{1'b0,12'h000, 1'b0,12'h000, 1'b1,12'h101, 1'b0,1'b0,1'b0, 4'd3 },  // R3 fill returns
        '{1'b1,12'h101, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd3 },  // R3 found in assist
        '{1'b1,12'h101, 1'b0,12'h000, 1'b0,12'h000, 1'b1,1'b0,1'b0, 4'd7 },  // R7 R5 promoted
        '{1'b0,12'h000, 1'b1,12'h201, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd4 },  // R4 prefetch
        '{1'b1,12'h201, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd4 },  // R4 assist only
        '{1'b1,12'h101, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd6 },  // R6 victim in assist
        '{1'b1,12'h201, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd6 },  // R6 swap back
        '{1'b0,12'h000, 1'b1,12'h302, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd8 },  // R8 stream
        '{1'b0,12'h000, 1'b1,12'h303, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd8 },
        '{1'b0,12'h000, 1'b1,12'h304, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd8 },
        '{1'b0,12'h000, 1'b1,12'h305, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd8 },
        '{1'b1,12'h101, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b0,1'b1, 4'd8 },  // R8 oldest gone
        '{1'b1,12'h201, 1'b0,12'h000, 1'b0,12'h000, 1'b1,1'b0,1'b0, 4'd8 },  // R8 main kept
        '{1'b0,12'h000, 1'b1,12'h303, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd9 },  // R9 dup in assist
        '{1'b0,12'h000, 1'b1,12'h201, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd9 },  // R9 dup in main
        '{1'b0,12'h000, 1'b1,12'h406, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd9 },
        '{1'b1,12'h304, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd9 },  // R9 survivor
        '{1'b1,12'h302, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b0,1'b1, 4'd8 },  // R8 evicted
        '{1'b0,12'h000, 1'b1,12'h508, 1'b1,12'h507, 1'b0,1'b0,1'b0, 4'd10},  // R10 both offered
        '{1'b1,12'h507, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd10},  // R10 fill kept
        '{1'b1,12'h508, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b0,1'b1, 4'd10},  // R10 prefetch dropped
        '{1'b0,12'h000, 1'b1,12'h601, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd11},
        '{1'b0,12'h000, 1'b1,12'h70A, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd11},
        '{1'b0,12'h000, 1'b1,12'h70B, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd11},
        '{1'b0,12'h000, 1'b1,12'h70C, 1'b0,12'h000, 1'b0,1'b0,1'b0, 4'd11},
        '{1'b1,12'h601, 1'b1,12'h80D, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd11},  // R11 promote + insert
        '{1'b1,12'h601, 1'b0,12'h000, 1'b0,12'h000, 1'b1,1'b0,1'b0, 4'd11},  // R11 promoted
        '{1'b1,12'h80D, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b1,1'b0, 4'd11},  // R11 insert kept
        '{1'b1,12'h201, 1'b0,12'h000, 1'b0,12'h000, 1'b0,1'b0,1'b1, 4'd11},  // R11 victim overwritten
        '{1'b1,12'h304, 1'b0,12'h000, 1'b0,12'h000, 1'b1,1'b0,1'b0, 4'd1 }   // R1 main hit
    };

    task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        lk_valid = v.lv; lk_addr = v.la;
        pf_valid = v.pv; pf_addr = v.pa;
        fill_valid = v.fv; fill_addr = v.fa;
        #5;
    endtask

    task automatic expect_out(input string req, input logic em, input logic ea,
                              input logic ef, input logic [AW-1:0] ea_addr);
        chk(req, "main_hit", AW'(main_hit), AW'(em));
        chk(req, "assist_hit", AW'(assist_hit), AW'(ea));
        chk(req, "fill_req", AW'(fill_req), AW'(ef));
        if (ef) chk(req, "fill_req_addr", fill_req_addr, ea_addr);
    endtask

    function automatic vec_t lookup(input logic [AW-1:0] a);
        vec_t v;
        v = '0;
        v.lv = 1'b1;
        v.la = a;
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R12: idle outputs right after reset
        expect_out("R12", 1'b0, 1'b0, 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            expect_out($sformatf("R%0d", TBL[i].rq), TBL[i].em, TBL[i].ea, TBL[i].ef, TBL[i].la);
        end

        // R12: reset mid-run empties both structures
        apply('0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        apply(lookup(12'h601));
        expect_out("R12", 1'b0, 1'b0, 1'b1, 12'h601);
        apply(lookup(12'h70A));
        expect_out("R12", 1'b0, 1'b0, 1'b1, 12'h70A);

        // R2: a miss leaves no trace; repeated miss still requests
        apply(lookup(12'hABC));
        expect_out("R2", 1'b0, 1'b0, 1'b1, 12'hABC);
        apply(lookup(12'hABC));
        expect_out("R2", 1'b0, 1'b0, 1'b1, 12'hABC);

        apply('0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule